// File: doc/BRIEF.md
# Display RAM Page/Column Addresser

This block sits between a host command stream and a single-port display memory. The memory is bit-mapped and has nine pages of 132 one-byte columns. Pages 0 to 7 each hold eight rows of pixels. Bit 0 of a byte is the top row of its page and bit 7 is the bottom row. Page 8 holds the icon row, and only bit 0 of its bytes carries information. The block keeps a page pointer, a column pointer and a segment-direction flag. Each one is loaded by its own host command.

A write or a read goes to the byte addressed by the current page and column. After the access the column pointer moves forward by one. It stops at the last column instead of wrapping, and the page pointer never moves by itself. To go on to the next page, the host must set both the page and the column again. Read data comes back on a response stream. A separate combinational path maps a segment index to the column it displays, and the direction flag mirrors that mapping.

Commands arrive on a valid/ready stream, and read data leaves on another valid/ready stream. Back-pressure works as follows: while a read response is held and the consumer is not ready, the block refuses new commands. A command is accepted on any cycle where `cmd_valid` and `cmd_ready` are both high. A response is consumed on any cycle where `rsp_valid` and `rsp_ready` are both high.

Top module: `dram_addresser`

## Requirements
- R1: After reset the page is 0, the column is 0, the direction flag is 0, `rsp_valid` is low and `cmd_ready` is high.
- R2: Opcode 0 loads the page pointer from `cmd_arg` when the value is 8 or less. Any larger value leaves the page unchanged.
- R3: Opcode 1 loads the column pointer from `cmd_arg`. A value above 131 is stored as 131.
- R4: An accepted write (opcode 2) or read (opcode 3) drives `mem_en` high in the same cycle, with the current page on `mem_page` and the current column on `mem_col`. `mem_we` is high only for a write, and `mem_wdata` carries `cmd_arg`. `mem_en` is low on every other cycle.
- R5: One cycle after a read is accepted, `rsp_valid` is high and `rsp_data` shows the byte the memory returned.
- R6: Every accepted write or read adds one to the column pointer, which stays at 131 once it reaches 131. These accesses never change the page pointer.
- R7: On page 8, bits 7..1 of the write data are driven as zero, and bits 7..1 of the read data are returned as zero.
- R8: Opcode 4 loads the direction flag from bit 0 of `cmd_arg`. For a segment index s in 0..131, `seg_col` is s when the flag is 0 and 131-s when the flag is 1.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `cmd_ready` is low and `rsp_data` holds steady. Otherwise `cmd_ready` is high.
- R10: Opcodes 5, 6 and 7 are accepted but change no pointer, no flag and no memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_op | input | 3 | Opcode: 0 page, 1 column, 2 write, 3 read, 4 direction |
| cmd_arg | input | 8 | Command operand or write byte |
| rsp_valid | output | 1 | Read byte present |
| rsp_ready | input | 1 | Consumer takes the read byte |
| rsp_data | output | 8 | Read byte |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write enable |
| mem_page | output | 4 | Memory page address |
| mem_col | output | 8 | Memory column address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after the request |
| seg_idx | input | 8 | Segment index to translate |
| seg_col | output | 8 | Column shown on that segment |

## Verification
The assertions rely on three things about the environment. The memory returns read data exactly one cycle after a read strobe. The host keeps `cmd_op` and `cmd_arg` at known values. Segment indices stay within 0..131. The bench meets these conditions in several ways: its memory model answers with a fixed one-cycle latency, every command field is driven from defined values, and `seg_idx` is drawn only from 0..131. Its random phase then mixes every opcode, covering out-of-range page and column arguments and `rsp_ready` stalls of random length.

// File: rtl/dram_pkg.sv
package dram_pkg;
  typedef enum logic [2:0] {
    OP_PAGE = 3'd0,
    OP_COL  = 3'd1,
    OP_WR   = 3'd2,
    OP_RD   = 3'd3,
    OP_DIR  = 3'd4
  } op_e;

  function automatic logic is_access(input logic [2:0] op);
    return (op == OP_WR) || (op == OP_RD);
  endfunction
endpackage

// File: rtl/dram_icon_mask.sv
// Keeps only the bits an icon-page byte may carry when sel is set.
module dram_icon_mask #(
  parameter int DATA_W   = 8,
  parameter int KEEP_BITS = 1
) (
  input  logic              sel,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (b < KEEP_BITS) begin : g_keep
      assign dout[b] = din[b];
    end else begin : g_clear
      assign dout[b] = din[b] & ~sel;
    end
  end
endmodule

// File: rtl/dram_ptr_regs.sv
// Page, column and direction state with their load and advance rules.
module dram_ptr_regs
  import dram_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_COLS  = 132,
  parameter int NUM_PAGES = 9,
  localparam int COL_W    = $clog2(NUM_COLS),
  localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc,
  input  logic [2:0]        op,
  input  logic [DATA_W-1:0] arg,
  output logic [PAGE_W-1:0] page,
  output logic [COL_W-1:0]  col,
  output logic              dir
);
  localparam int LAST_COL  = NUM_COLS - 1;
  localparam int LAST_PAGE = NUM_PAGES - 1;

  logic [COL_W-1:0]  col_load;
  logic [COL_W-1:0]  col_step;
  logic              page_ok;
  logic              col_big;

  always_comb begin
    page_ok  = (int'(arg) <= LAST_PAGE);
    col_big  = (int'(arg) > LAST_COL);
    col_load = col_big ? COL_W'(LAST_COL) : COL_W'(arg);
    col_step = (col == COL_W'(LAST_COL)) ? col : col + COL_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      page <= '0;
      col  <= '0;
      dir  <= 1'b0;
    end else if (acc) begin
      case (op)
        OP_PAGE: if (page_ok) page <= PAGE_W'(arg);
        OP_COL:  col <= col_load;
        OP_WR,
        OP_RD:   col <= col_step;
        OP_DIR:  dir <= arg[0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dram_rsp_path.sv
// Read response register with a live first beat and a held copy under stall.
module dram_rsp_path #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_acc,
  input  logic              rd_icon,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  logic              fresh_q;
  logic              icon_q;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] live;

  dram_icon_mask #(.DATA_W(DATA_W), .KEEP_BITS(1)) u_rd_mask (
    .sel  (icon_q),
    .din  (mem_rdata),
    .dout (live)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      fresh_q   <= 1'b0;
      icon_q    <= 1'b0;
      hold_q    <= '0;
    end else begin
      fresh_q <= rd_acc;
      if (rd_acc) icon_q <= rd_icon;
      if (fresh_q) hold_q <= live;
      if (rd_acc) rsp_valid <= 1'b1;
      else if (rsp_ready) rsp_valid <= 1'b0;
    end
  end

  assign rsp_data = fresh_q ? live : hold_q;
endmodule

// File: rtl/dram_seg_map.sv
// Column shown on a given segment, mirrored when the direction flag is set.
module dram_seg_map #(
  parameter int NUM_COLS = 132,
  localparam int COL_W   = $clog2(NUM_COLS)
) (
  input  logic             dir,
  input  logic [COL_W-1:0] idx,
  output logic [COL_W-1:0] col
);
  localparam logic [COL_W-1:0] LAST = COL_W'(NUM_COLS - 1);
  assign col = dir ? (LAST - idx) : idx;
endmodule

// File: rtl/dram_addresser.sv
module dram_addresser
  import dram_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int NUM_COLS  = 132,
  parameter int NUM_PAGES = 9,
  localparam int COL_W    = $clog2(NUM_COLS),
  localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_arg,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_en,
  output logic              mem_we,
  output logic [PAGE_W-1:0] mem_page,
  output logic [COL_W-1:0]  mem_col,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [COL_W-1:0]  seg_idx,
  output logic [COL_W-1:0]  seg_col
);
  localparam logic [PAGE_W-1:0] ICON_PAGE = PAGE_W'(NUM_PAGES - 1);

  logic              acc;
  logic              rd_acc;
  logic              on_icon;
  logic [PAGE_W-1:0] page_q;
  logic [COL_W-1:0]  col_q;
  logic              dir_q;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign acc       = cmd_valid && cmd_ready;
  assign rd_acc    = acc && (cmd_op == OP_RD);
  assign on_icon   = (page_q == ICON_PAGE);

  dram_ptr_regs #(
    .DATA_W(DATA_W), .NUM_COLS(NUM_COLS), .NUM_PAGES(NUM_PAGES)
  ) u_ptr (
    .clk  (clk),
    .rst_n(rst_n),
    .acc  (acc),
    .op   (cmd_op),
    .arg  (cmd_arg),
    .page (page_q),
    .col  (col_q),
    .dir  (dir_q)
  );

  assign mem_en   = acc && is_access(cmd_op);
  assign mem_we   = acc && (cmd_op == OP_WR);
  assign mem_page = page_q;
  assign mem_col  = col_q;

  dram_icon_mask #(.DATA_W(DATA_W), .KEEP_BITS(1)) u_wr_mask (
    .sel  (on_icon),
    .din  (cmd_arg),
    .dout (mem_wdata)
  );

  dram_rsp_path #(.DATA_W(DATA_W)) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_acc   (rd_acc),
    .rd_icon  (on_icon),
    .mem_rdata(mem_rdata),
    .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data)
  );

  dram_seg_map #(.NUM_COLS(NUM_COLS)) u_seg (
    .dir(dir_q),
    .idx(seg_idx),
    .col(seg_col)
  );
endmodule

// File: rtl/dram_addresser_chk.sv
module dram_addresser_chk #(
  parameter int DATA_W    = 8,
  parameter int NUM_COLS  = 132,
  parameter int NUM_PAGES = 9,
  localparam int COL_W    = $clog2(NUM_COLS),
  localparam int PAGE_W   = $clog2(NUM_PAGES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [2:0]        cmd_op,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [DATA_W-1:0] rsp_data,
  input logic              mem_en,
  input logic              mem_we,
  input logic [PAGE_W-1:0] mem_page,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [PAGE_W-1:0] page_q,
  input logic [COL_W-1:0]  col_q
);
  localparam logic [COL_W-1:0]  LAST_COL  = COL_W'(NUM_COLS - 1);
  localparam logic [PAGE_W-1:0] ICON_PAGE = PAGE_W'(NUM_PAGES - 1);

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R5
  read_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready && cmd_op == 3'd3) |=> rsp_valid);

  // R4
  mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> (cmd_valid && cmd_ready));

  // R4
  mem_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> mem_en);

  // R6
  col_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    col_q <= LAST_COL);

  // R6
  page_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |=> $stable(page_q));

  // R2
  page_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    page_q <= ICON_PAGE);

  // R7
  icon_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && mem_page == ICON_PAGE) |-> (mem_wdata[DATA_W-1:1] == '0));
endmodule

bind dram_addresser dram_addresser_chk #(
  .DATA_W(DATA_W), .NUM_COLS(NUM_COLS), .NUM_PAGES(NUM_PAGES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cmd_valid(cmd_valid),
  .cmd_ready(cmd_ready),
  .cmd_op   (cmd_op),
  .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready),
  .rsp_data (rsp_data),
  .mem_en   (mem_en),
  .mem_we   (mem_we),
  .mem_page (mem_page),
  .mem_wdata(mem_wdata),
  .page_q   (page_q),
  .col_q    (col_q)
);

// File: tb/dram_addresser_bench.sv
module dram_addresser_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NCOL = 132;
  localparam int NPAGE = 9;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic       cmd_ready;
  logic [2:0] cmd_op = 3'd0;
  logic [7:0] cmd_arg = 8'd0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic       mem_en;
  logic       mem_we;
  logic [3:0] mem_page;
  logic [7:0] mem_col;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'd0;
  logic [7:0] seg_idx = 8'd0;
  logic [7:0] seg_col;

  int total = 0;
  int bad = 0;

  // bench-side memory, one-cycle read latency
  logic [7:0] bmem [NPAGE][NCOL];
  // reference model state
  int m_page, m_col, m_dir;
  bit m_rv;
  int m_rd;
  int ref_mem [NPAGE][NCOL];

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_addresser u_dram_addresser (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_arg(cmd_arg),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .mem_en(mem_en), .mem_we(mem_we), .mem_page(mem_page), .mem_col(mem_col),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .seg_idx(seg_idx), .seg_col(seg_col)
  );

  always @(posedge clk) begin
    if (mem_en && int'(mem_page) < NPAGE && int'(mem_col) < NCOL) begin
      if (mem_we) bmem[mem_page][mem_col] <= mem_wdata;
      else mem_rdata <= bmem[mem_page][mem_col];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // One cycle: inputs set at negedge, outputs compared, model advanced.
  task automatic step(input bit v, input int op, input int arg, input bit rr,
                      input string tag);
    bit acc, exp_en;
    int wv;
    cmd_valid = v;
    cmd_op    = 3'(op);
    cmd_arg   = 8'(arg);
    rsp_ready = rr;
    seg_idx   = 8'($urandom_range(0, NCOL-1));
    #1;
    acc    = v && (!m_rv || rr);
    exp_en = acc && (op == 2 || op == 3);
    wv     = (m_page == 8) ? (arg & 1) : arg;
    chk(cmd_ready == (!m_rv || rr), {tag, " R9"}, "cmd_ready", int'(cmd_ready), int'(!m_rv || rr));
    chk(mem_en == exp_en, {tag, " R4"}, "mem_en", int'(mem_en), int'(exp_en));
    chk(mem_we == (acc && op == 2), {tag, " R4"}, "mem_we", int'(mem_we), int'(acc && op == 2));
    if (exp_en) begin
      chk(int'(mem_page) == m_page, {tag, " R4"}, "mem_page", int'(mem_page), m_page);
      chk(int'(mem_col) == m_col, {tag, " R4"}, "mem_col", int'(mem_col), m_col);
      if (op == 2)
        chk(int'(mem_wdata) == wv, {tag, " R7"}, "mem_wdata", int'(mem_wdata), wv);
    end
    chk(rsp_valid == m_rv, {tag, " R5"}, "rsp_valid", int'(rsp_valid), int'(m_rv));
    if (m_rv)
      chk(int'(rsp_data) == m_rd, {tag, " R5"}, "rsp_data", int'(rsp_data), m_rd);
    begin
      int es;
      es = m_dir ? (NCOL - 1 - int'(seg_idx)) : int'(seg_idx);
      chk(int'(seg_col) == es, {tag, " R8"}, "seg_col", int'(seg_col), es);
    end
    // advance model
    if (m_rv && rr) m_rv = 0;
    if (acc) begin
      case (op)
        0: if (arg <= 8) m_page = arg;
        1: m_col = (arg > NCOL - 1) ? NCOL - 1 : arg;
        2: begin
          ref_mem[m_page][m_col] = wv;
          if (m_col < NCOL - 1) m_col++;
        end
        3: begin
          m_rv = 1;
          m_rd = (m_page == 8) ? (ref_mem[m_page][m_col] & 1) : ref_mem[m_page][m_col];
          if (m_col < NCOL - 1) m_col++;
        end
        4: m_dir = arg & 1;
        default: ;
      endcase
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int p = 0; p < NPAGE; p++)
      for (int c = 0; c < NCOL; c++) begin
        bmem[p][c]    = (p == 8) ? 8'hA5 : 8'(p * 16 + c);
        ref_mem[p][c] = (p == 8) ? 'hA5 : ((p * 16 + c) & 255);
      end
    m_page = 0; m_col = 0; m_dir = 0; m_rv = 0; m_rd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(cmd_ready == 1'b1, "R1", "cmd_ready", int'(cmd_ready), 1);
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", int'(rsp_valid), 0);
    @(negedge clk);
    step(1, 3, 0, 1, "R1");              // read at page 0 col 0
    step(1, 2, 8'h3C, 1, "R4");
    step(1, 2, 8'hC3, 1, "R4");
    step(0, 2, 8'h11, 1, "R4");          // idle: no strobe
    step(1, 1, 200, 1, "R3");            // clamp to 131
    step(1, 2, 8'h77, 1, "R3");
    step(1, 1, 130, 1, "R6");
    step(1, 2, 8'h01, 1, "R6");
    step(1, 2, 8'h02, 1, "R6");
    step(1, 2, 8'h03, 1, "R6");          // stays at 131
    step(1, 0, 5, 1, "R2");
    step(1, 0, 9, 1, "R2");              // ignored
    step(1, 0, 255, 1, "R2");            // ignored
    step(1, 1, 130, 1, "R2");
    step(1, 3, 0, 1, "R5");
    step(1, 3, 0, 1, "R5");
    step(0, 0, 0, 1, "R5");
    step(1, 0, 8, 1, "R7");
    step(1, 1, 10, 1, "R7");
    step(1, 2, 8'hFF, 1, "R7");
    step(1, 1, 10, 1, "R7");
    step(1, 3, 0, 1, "R7");
    step(1, 3, 0, 1, "R7");              // preloaded 0xA5 read back
    step(0, 0, 0, 1, "R7");
    step(1, 3, 0, 0, "R9");
    step(1, 2, 8'h55, 0, "R9");          // refused
    step(1, 2, 8'h55, 0, "R9");
    step(1, 2, 8'h55, 1, "R9");          // accepted with handshake
    step(1, 4, 1, 1, "R8");
    for (int i = 0; i < 6; i++) step(0, 0, 0, 1, "R8");
    step(1, 4, 2, 1, "R8");              // bit0 = 0
    step(1, 5, 3, 1, "R10");
    step(1, 6, 200, 1, "R10");
    step(1, 7, 255, 1, "R10");
    step(1, 3, 0, 1, "R10");
    for (int i = 0; i < 4000; i++) begin
      int op, arg;
      op  = $urandom_range(0, 7);
      arg = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 255)
          : (op == 0 ? $urandom_range(0, 9) : $urandom_range(0, 140));
      step($urandom_range(0, 3) != 0, op, arg, $urandom_range(0, 2) != 0, "RND");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule